// File: doc/BRIEF.md
# Polyphase Quadrature-to-Real Interpolating Upconverter

This block turns a complex baseband stream (a real and an imaginary sample per input step) into one real stream at twice the input rate. It interpolates by two with a halfband-style filter and shifts the spectrum by a quarter of the output rate. Zero-stuffing, filtering and mixing collapse into two short polyphase sub-filters. The real samples run through the even-indexed coefficients and the imaginary samples run through the odd-indexed ones. Each sub-filter result is multiplied by a mix factor of +2 or -2, which makes up for the interpolation loss. The result is then rounded and saturated back to the sample width.

The block has two output modes. In the interleaved mode it takes one complex sample on every second clock and emits one real sample per clock on `out_a`, with the imaginary-leg product first and the real-leg product second. In the dual mode it takes a complex sample on every clock and presents both products at once. The imaginary-leg product appears on `out_b` and comes first in sample order, and the real-leg product appears on `out_a`. A sideband input chooses whether the complex spectrum lands in the upper or the lower sideband of the real output. A sync input restarts the mixing phase.

Top module: `qr_upconv`

## Requirements
- R1: While `rst_n` is low, `out_a` and `out_b` are 0.
- R2: For loaded sample m, the real-leg value is A_m = sat(round(2·s·(C0·R_m + C2·R_{m-1} + C4·R_{m-2} + C6·R_{m-3}) / 2^15)). Here s = +1 when the phase parity of sample m is 0 and s = -1 when it is 1. Coefficients are Q15 and packed with C0 in the least significant 16 bits of `COEFS`. Samples from before reset count as 0.
- R3: With `usb_sel`=1, the imaginary-leg value is B_m = sat(round(2·s·(C1·I_m + C3·I_{m-1} + C5·I_{m-2}) / 2^15)), with s = -1 at parity 0 and s = +1 at parity 1.
- R4: With `usb_sel`=0, the sign sequence of the imaginary leg is inverted (s = +1 at parity 0). `usb_sel` is taken together with each sample and ignored on every other edge.
- R5: Interleaved mode (`dual_out`=0): a sample loads on the first non-sync edge after reset or sync, and then on every second edge. `out_a` shows B_m after the second edge following the load edge and A_m after the third. `out_b` stays 0. Inputs present on non-load edges have no effect.
- R6: An edge with `sync`=1 loads nothing. The next edge without sync loads a sample with phase parity 0, and the parity toggles with every loaded sample. Sync does not clear the tap history.
- R7: Dual mode (`dual_out`=1): a sample loads on every edge without sync. After the second edge following the load, `out_a`=A_m and `out_b`=B_m.
- R8: Rounding adds 2^14 to the mixed sum and then floors, so an exact half rounds toward plus infinity.
- R9: Results saturate to the range -32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_out | input | 1 | 0 = interleaved output on out_a, 1 = both legs on separate outputs; static outside reset |
| usb_sel | input | 1 | 1 = upper sideband, 0 = lower sideband; taken with each sample |
| sync | input | 1 | Restart mixing phase; the following load gets parity 0 |
| re_in | input | 16 | Real component, signed |
| im_in | input | 16 | Imaginary component, signed |
| out_a | output | 16 | Interleaved real stream, or real-leg result in dual mode |
| out_b | output | 16 | Imaginary-leg result in dual mode, 0 otherwise |

## Verification
A wrong phase parity flips the sign of every following product. That error shows at the ports within three clocks of the next load and persists until a sync. A shifted or stale tap register corrupts every output that uses that tap, so the first nonzero sample exposes it within four loads. A wrong interleave select swaps the order of B and A on `out_a` on the first pair. Rounding and saturation faults show only on the directed half-value and full-scale samples, because random data rarely hits those values.

// File: rtl/qru_pkg.sv
package qru_pkg;
  localparam int unsigned QRU_DW    = 16;
  localparam int unsigned QRU_CW    = 16;
  localparam int unsigned QRU_NTAPS = 7;
  localparam int unsigned QRU_FRAC  = 15;

  // Q15 halfband-style prototype, C0 in the low 16 bits (symmetric)
  localparam logic [QRU_NTAPS*QRU_CW-1:0] QRU_COEFS = {
    -16'sd3000, 16'sd6000, 16'sd17000, 16'sd26000,
    16'sd17000, 16'sd6000, -16'sd3000
  };

  typedef enum logic {
    OUT_INTERLEAVED = 1'b0,
    OUT_DUAL        = 1'b1
  } qru_outmode_e;
endpackage

// File: rtl/qru_ctrl.sv
module qru_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_out,
  input  logic sync,
  output logic load,
  output logic par,
  output logic fresh,
  output logic fresh2
);
  logic ld_q, ld_n;
  logic par_q, par_n;
  logic fresh_q, fresh2_q;

  assign load = !sync && (ld_q || dual_out);

  always_comb begin
    ld_n  = ld_q;
    par_n = par_q;
    if (sync) begin
      ld_n  = 1'b1;
      par_n = 1'b0;
    end else if (load) begin
      ld_n  = 1'b0;
      par_n = ~par_q;
    end else begin
      ld_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q     <= 1'b1;
      par_q    <= 1'b0;
      fresh_q  <= 1'b0;
      fresh2_q <= 1'b0;
    end else begin
      ld_q     <= ld_n;
      par_q    <= par_n;
      fresh_q  <= load;
      fresh2_q <= fresh_q;
    end
  end

  assign par    = par_q;
  assign fresh  = fresh_q;
  assign fresh2 = fresh2_q;

  p_one_in_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_out && load) |=> !load);
  p_sync_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (load || sync));
  p_par_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (par == 1'b0));
  p_dual_every_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_out && !sync) |=> fresh);
endmodule

// File: rtl/qru_leg.sv
module qru_leg #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned NTAPS = 7,
  parameter int unsigned FRAC  = 15,
  parameter int unsigned ODD   = 0,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 neg_in,
  input  logic                 fresh,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] res
);
  localparam int unsigned NT = (ODD != 0) ? NTAPS / 2 : (NTAPS + 1) / 2;
  localparam int unsigned PW = DW + CW;
  localparam int unsigned AW = PW + $clog2(NT) + 3;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] SMAX = (AW'(1) << (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] SMIN = -(AW'(1) << (DW - 1));

  logic signed [DW-1:0] dl_q [NT];
  logic signed [DW-1:0] dl_n [NT];
  logic                 neg_q, neg_n;
  logic signed [PW-1:0] prod [NT];
  logic signed [AW-1:0] acc, dbl, mixed, rnd;
  logic signed [DW-1:0] res_q, res_n;

  // one product per sub-filter tap: tap g uses coefficient 2g+ODD
  for (genvar g = 0; g < NT; g++) begin : g_tap
    localparam logic signed [CW-1:0] CK = COEFS[(2*g+ODD)*CW +: CW];
    assign prod[g] = PW'(dl_q[g]) * PW'(CK);
  end

  always_comb begin
    for (int i = 0; i < NT; i++) dl_n[i] = dl_q[i];
    neg_n = neg_q;
    if (load) begin
      dl_n[0] = x_in;
      for (int i = 1; i < NT; i++) dl_n[i] = dl_q[i-1];
      neg_n = neg_in;
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NT; i++) acc = acc + AW'(prod[i]);
    dbl   = acc <<< 1;
    mixed = neg_q ? -dbl : dbl;
    rnd   = (mixed + HALF) >>> FRAC;
    res_n = res_q;
    if (fresh) begin
      if (rnd > SMAX)      res_n = SMAX[DW-1:0];
      else if (rnd < SMIN) res_n = SMIN[DW-1:0];
      else                 res_n = rnd[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) dl_q[i] <= '0;
      neg_q <= 1'b0;
      res_q <= '0;
    end else begin
      for (int i = 0; i < NT; i++) dl_q[i] <= dl_n[i];
      neg_q <= neg_n;
      res_q <= res_n;
    end
  end

  assign res = res_q;
endmodule

// File: rtl/qru_outmux.sv
module qru_outmux import qru_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_out,
  input  logic                 fresh2,
  input  logic signed [DW-1:0] a_res,
  input  logic signed [DW-1:0] b_res,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  qru_outmode_e mode;
  logic signed [DW-1:0] a_q, a_n, b_q, b_n;

  assign mode = qru_outmode_e'(dual_out);

  always_comb begin
    case (mode)
      OUT_DUAL: begin
        a_n = a_res;
        b_n = b_res;
      end
      default: begin
        // imaginary-leg product first, real-leg product on the next clock
        a_n = fresh2 ? b_res : a_res;
        b_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_n;
      b_q <= b_n;
    end
  end

  assign out_a = a_q;
  assign out_b = b_q;

  p_outb_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_out |=> (out_b == '0));
  p_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_out && fresh2) |=> !fresh2);
endmodule

// File: rtl/qr_upconv.sv
module qr_upconv import qru_pkg::*; #(
  parameter int unsigned DW    = QRU_DW,
  parameter int unsigned CW    = QRU_CW,
  parameter int unsigned NTAPS = QRU_NTAPS,
  parameter int unsigned FRAC  = QRU_FRAC,
  parameter logic [NTAPS*CW-1:0] COEFS = QRU_COEFS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_out,
  input  logic                 usb_sel,
  input  logic                 sync,
  input  logic signed [DW-1:0] re_in,
  input  logic signed [DW-1:0] im_in,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  logic load, par, fresh, fresh2;
  logic odd_neg;
  logic signed [DW-1:0] a_res, b_res;

  // upper sideband: imaginary leg takes -2 at parity 0; lower flips it
  assign odd_neg = par ^ usb_sel;

  qru_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dual_out(dual_out), .sync(sync),
    .load(load), .par(par), .fresh(fresh), .fresh2(fresh2)
  );

  qru_leg #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .FRAC(FRAC), .ODD(0), .COEFS(COEFS)) u_even (
    .clk(clk), .rst_n(rst_n), .load(load), .neg_in(par), .fresh(fresh),
    .x_in(re_in), .res(a_res)
  );

  qru_leg #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .FRAC(FRAC), .ODD(1), .COEFS(COEFS)) u_odd (
    .clk(clk), .rst_n(rst_n), .load(load), .neg_in(odd_neg), .fresh(fresh),
    .x_in(im_in), .res(b_res)
  );

  qru_outmux #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .dual_out(dual_out), .fresh2(fresh2),
    .a_res(a_res), .b_res(b_res), .out_a(out_a), .out_b(out_b)
  );
endmodule

// File: tb/qr_upconv_tb_top.sv
module qr_upconv_tb_top;
  localparam int NTP   = 7;
  localparam int DEPTH = 8192;
  localparam int HN    = 2048;
  localparam int BC   [NTP] = '{-3000, 6000, 17000, 26000, 17000, 6000, -3000};
  localparam int COSQ [4]   = '{0, 1, 0, -1};
  localparam int SINQ [4]   = '{-1, 0, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0, dual_out = 1'b0, usb_sel = 1'b1, sync = 1'b0;
  logic signed [15:0] re_in = '0, im_in = '0;
  logic signed [15:0] out_a, out_b;

  always #10 clk = ~clk;

  qr_upconv #(.COEFS({-16'sd3000, 16'sd6000, 16'sd17000, 16'sd26000,
                      16'sd17000, 16'sd6000, -16'sd3000})) dut_i (
    .clk(clk), .rst_n(rst_n), .dual_out(dual_out), .usb_sel(usb_sel),
    .sync(sync), .re_in(re_in), .im_in(im_in), .out_a(out_a), .out_b(out_b)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;
  logic signed [15:0] ea [DEPTH];
  logic signed [15:0] eb [DEPTH];
  bit va [DEPTH];
  bit vb [DEPTH];
  string ta [DEPTH];
  int hr [HN];
  int hi [HN];
  bit hu [HN];
  bit hp [HN];
  int m = 0;
  bit bpar = 1'b0;
  bit timed_out = 1'b0;

  function automatic longint xr(int t, int mm);
    int j;
    if ((t & 1) == 0) return 0;
    j = (t - 1) / 2;
    if (t < 0 || j > mm) return 0;
    return longint'(hr[j]);
  endfunction

  function automatic longint xi(int t, int mm);
    int j;
    if ((t & 1) == 0) return 0;
    j = (t + 1) / 2;
    if (t < -1 || j > mm) return 0;
    return longint'(hi[j]);
  endfunction

  function automatic logic signed [15:0] rsat(longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return 16'(r);
  endfunction

  // zero-stuffed full FIR, then cos/sin mix, x2 gain
  function automatic logic signed [15:0] ref_out(int mm, bit half);
    longint fr, fi;
    int n, q, c, s;
    fr = 0; fi = 0;
    n = 2 * mm + int'(half);
    for (int k = 0; k < NTP; k++) begin
      fr += longint'(BC[k]) * xr(n - k, mm);
      fi += longint'(BC[k]) * xi(n - k, mm);
    end
    q = 2 * int'(hp[mm]) + int'(half);
    c = COSQ[q];
    s = hu[mm] ? SINQ[q] : -SINQ[q];
    return rsat(2 * (longint'(c) * fr + longint'(s) * fi));
  endfunction

  always @(negedge clk) begin
    if (rst_n && cyc < DEPTH) begin
      if (va[cyc]) begin
        n_chk++;
        if (out_a !== ea[cyc]) begin
          n_bad++;
          $display("FAIL %s out_a cycle %0d actual %0d expected %0d", ta[cyc], cyc, out_a, ea[cyc]);
        end
      end
      if (vb[cyc]) begin
        n_chk++;
        if (out_b !== eb[cyc]) begin
          n_bad++;
          $display("FAIL %s out_b cycle %0d actual %0d expected %0d", ta[cyc], cyc, out_b, eb[cyc]);
        end
      end
    end
  end

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; dual_out = mode; sync = 1'b1; re_in = '0; im_in = '0;
    repeat (2) @(negedge clk);
    n_chk++;
    if (out_a !== 16'sd0 || out_b !== 16'sd0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual %0d/%0d expected 0/0", out_a, out_b);
    end
    rst_n = 1'b1;   // first edge after release carries sync: no load
    m = 0; bpar = 1'b0;
  endtask

  task automatic give(input logic signed [15:0] r, input logic signed [15:0] i,
                      input bit u, input string tag);
    int k;
    @(negedge clk);
    sync = 1'b0; re_in = r; im_in = i; usb_sel = u;
    k = cyc + 1;
    hr[m] = int'(r); hi[m] = int'(i); hu[m] = u; hp[m] = bpar;
    if (!dual_out) begin
      ea[k+2] = ref_out(m, 1'b0); va[k+2] = 1'b1; eb[k+2] = '0; vb[k+2] = 1'b1; ta[k+2] = tag;
      ea[k+3] = ref_out(m, 1'b1); va[k+3] = 1'b1; eb[k+3] = '0; vb[k+3] = 1'b1; ta[k+3] = tag;
    end else begin
      ea[k+2] = ref_out(m, 1'b1); va[k+2] = 1'b1;
      eb[k+2] = ref_out(m, 1'b0); vb[k+2] = 1'b1; ta[k+2] = tag;
    end
    m++;
    bpar = ~bpar;
    if (!dual_out) begin
      @(negedge clk);   // non-load edge: junk must be ignored (R5, R4)
      re_in = 16'($urandom); im_in = 16'($urandom); usb_sel = 1'($urandom);
    end
  endtask

  task automatic resync();
    @(negedge clk);
    sync = 1'b1; re_in = 16'($urandom); im_in = 16'($urandom); usb_sel = 1'($urandom);
    bpar = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    fork
      begin
        do_reset(1'b0);
        // R8: 2*(-3000*1024)/2^15 = -187.5, rounds to -187
        give(16'sd1024, 16'sd0, 1'b1, "R8 R2 R3");
        give(16'sd0, 16'sd0, 1'b1, "R8");
        // R9: full-scale runs in both sidebands
        repeat (4) give(16'sd32767, 16'sd32767, 1'b1, "R9");
        repeat (4) give(-16'sd32768, -16'sd32768, 1'b0, "R9");
        repeat (4) give(16'sd32767, -16'sd32768, 1'b0, "R9 R4");
        for (int n = 0; n < 60; n++)
          give(16'($urandom), 16'($urandom), 1'($urandom), "R2 R3 R4 R5");
        resync();
        for (int n = 0; n < 10; n++)
          give(16'($urandom), 16'($urandom), 1'b1, "R6 R5");
        resync();
        resync();
        for (int n = 0; n < 9; n++)
          give(16'($urandom), 16'($urandom), 1'($urandom), "R6");
        resync();
        for (int n = 0; n < 6; n++)
          give(16'($urandom), 16'($urandom), 1'b0, "R6 R4");
        repeat (5) @(negedge clk);
        do_reset(1'b1);
        give(16'sd1024, 16'sd0, 1'b1, "R7 R8");
        repeat (4) give(16'sd32767, 16'sd32767, 1'b0, "R7 R9");
        for (int n = 0; n < 60; n++)
          give(16'($urandom), 16'($urandom), 1'($urandom), "R7 R2 R3 R4");
        resync();
        for (int n = 0; n < 20; n++)
          give(16'($urandom), 16'($urandom), 1'($urandom), "R7 R6");
        repeat (5) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule